// File: doc/BRIEF.md
# Synchronous FIFO Pointer Control with Fall-Through and Replay

This block is a single-clock FIFO. It stores words in an internal register array and keeps one write pointer and one read pointer. Two read timing styles are chosen at master reset. In the standard style a stored word reaches the output only when a read is requested. In the fall-through style the oldest word is moved to the output by itself, and a ready flag marks it as valid. Two flag outputs change meaning with the style: empty/full in standard, output-ready/input-ready in fall-through. A half-full flag is present in both styles.

A replay input moves the read pointer back to the first memory location, so the same words can be read again. A mode pin latched at master reset selects the replay timing. In zero-latency timing the first word is on the output after the same edge that samples the replay request. In one-cycle timing it appears one cycle later, and that cycle ignores reads. A partial reset clears both pointers and keeps the two latched modes. All enables and resets are active low and sampled on the rising clock edge. Replay is intended for runs in which no more than DEPTH words have been written since the last reset.

Top module: `fifo_rdctl`

## Requirements
- R1: While `mrst_n` is low on an edge, both pointers and `dout` clear to zero, `fall_pin` and `rtlat_n` are latched, and after release the flags read: standard mode `ef_or`=1, `ff_ir`=0; fall-through mode `ef_or`=0, `ff_ir`=1; `half_full`=0.
- R2: In standard mode (`fall_pin`=0 at master reset), a written word does not change `dout`. Each edge with `rd_n` low and the FIFO not empty loads the oldest word into `dout`. Words come out in write order, and `ef_or`=1 marks an empty memory.
- R3: In standard mode, a read on an edge where `ef_or`=1 leaves `dout` and the pointers unchanged.
- R4: In fall-through mode (`fall_pin`=1 at master reset), a word written into an empty FIFO on edge N is on `dout` with `ef_or`=1 after edge N+1, with no read. Later words advance only on edges with `rd_n` low. A read of the last word with nothing behind it drops `ef_or` to 0.
- R5: When the memory holds DEPTH words that have not been presented, the full indication is raised: `ff_ir`=1 in standard mode, `ff_ir`=0 in fall-through mode. While it is raised, writes are ignored.
- R6: `half_full` is 1 exactly when the held words exceed DEPTH/2. Held words are the memory count, plus the presented word in fall-through mode.
- R7: With `rtlat_n`=0 at master reset, an edge with `rt_n` low loads the word at memory location 0 into `dout` on that same edge. The next read returns location 1.
- R8: With `rtlat_n`=1 at master reset, the word at location 0 reaches `dout` one edge after the `rt_n` edge. A read on that intermediate edge is ignored.
- R9: An edge with `prst_n` low clears both pointers, `dout` and the fall-through ready state, and keeps the latched timing and replay modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| prst_n | input | 1 | Partial reset, active low, synchronous |
| fall_pin | input | 1 | Timing style sampled at master reset: 1 fall-through, 0 standard |
| rtlat_n | input | 1 | Replay timing sampled at master reset: 0 zero latency, 1 one-cycle |
| wr_n | input | 1 | Write enable, active low |
| din | input | W | Write data |
| rd_n | input | 1 | Read enable, active low |
| rt_n | input | 1 | Replay request, active low |
| dout | output | W | Output data register |
| ef_or | output | 1 | Empty (standard) or output ready (fall-through) |
| ff_ir | output | 1 | Full (standard) or input ready (fall-through) |
| half_full | output | 1 | More than DEPTH/2 words held |

## Verification
The bench fills the FIFO to exactly DEPTH words and then tries one more write. A design that lets this write through corrupts the oldest entry, and the sixteen words read back expose it. It reads an empty FIFO in standard mode: a design that skips the empty guard advances the read pointer and puts a stale word on the output. In fall-through mode it checks that the first word shows up unprompted and that the next words wait for a read. A design that streams every word through would show the wrong word on idle cycles. Both replay timings are covered, including a read held low during the one-cycle gap. A design that obeys that read lands one word late. A partial reset in fall-through mode must leave the ready-flag meaning in place, which a design that forgets the latched mode would lose.

// File: rtl/fifo_rdctl.sv
module fifo_rdctl #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         mrst_n,
  input  logic         prst_n,
  input  logic         fall_pin,
  input  logic         rtlat_n,
  input  logic         wr_n,
  input  logic [W-1:0] din,
  input  logic         rd_n,
  input  logic         rt_n,
  output logic [W-1:0] dout,
  output logic         ef_or,
  output logic         ff_ir,
  output logic         half_full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0]   DEPTH_C = (AW+1)'(DEPTH);
  localparam logic [AW+1:0] HALF_C  = (AW+2)'(DEPTH / 2);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;
  logic [W-1:0] q;
  logic         fwft, zlat, ov, rt_pend;

  wire [AW:0]   used      = wptr - rptr;
  wire          mem_empty = (used == '0);
  wire          full      = (used == DEPTH_C);
  wire          wr_ok     = !wr_n && !full;
  wire          have_data = (wptr != '0);
  wire          take      = !mem_empty && (fwft ? (!ov || !rd_n) : !rd_n);
  wire [AW+1:0] held      = {1'b0, used} + (AW+2)'(fwft && ov);

  always_ff @(posedge clk)
    if (mrst_n && prst_n && wr_ok) mem[wptr[AW-1:0]] <= din;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      fwft    <= fall_pin;
      zlat    <= !rtlat_n;
      wptr    <= '0;
      rptr    <= '0;
      ov      <= 1'b0;
      rt_pend <= 1'b0;
      q       <= '0;
    end else if (!prst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      ov      <= 1'b0;
      rt_pend <= 1'b0;
      q       <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (!rt_n) begin
        rt_pend <= !zlat;
        if (zlat && have_data) begin
          q    <= mem[0];
          rptr <= (AW+1)'(1);
          ov   <= 1'b1;
        end else begin
          rptr <= '0;
          ov   <= 1'b0;
        end
      end else if (rt_pend) begin
        rt_pend <= 1'b0;
        if (have_data) begin
          q    <= mem[0];
          rptr <= (AW+1)'(1);
          ov   <= 1'b1;
        end
      end else if (take) begin
        q    <= mem[rptr[AW-1:0]];
        rptr <= rptr + 1'b1;
        ov   <= 1'b1;
      end else if (fwft && !rd_n) begin
        ov <= 1'b0;
      end
    end
  end

  assign dout      = q;
  assign ef_or     = fwft ? ov : mem_empty;
  assign ff_ir     = fwft ? !full : full;
  assign half_full = held > HALF_C;
endmodule

module fifo_rdctl_chk #(
  parameter int AW = 4,
  parameter int W  = 8
) (
  input logic         clk,
  input logic         mrst_n,
  input logic         prst_n,
  input logic         rd_n,
  input logic         rt_n,
  input logic         fwft,
  input logic         zlat,
  input logic         ef_or,
  input logic         ff_ir,
  input logic         half_full,
  input logic [W-1:0] dout,
  input logic [AW:0]  wptr,
  input logic [AW:0]  rptr
);
  wire full_now = fwft ? !ff_ir : ff_ir;

  assert_prst_clears_R9: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> (wptr == '0 && rptr == '0));

  assert_full_blocks_R5: assert property (@(posedge clk) disable iff (!mrst_n)
    (prst_n && full_now) |=> wptr == $past(wptr));

  assert_empty_read_R3: assert property (@(posedge clk) disable iff (!mrst_n)
    (!fwft && ef_or && prst_n && rt_n) |=> $stable(dout));

  assert_zero_rt_R7: assert property (@(posedge clk) disable iff (!mrst_n)
    (zlat && !rt_n && prst_n && wptr != '0) |=> rptr == (AW+1)'(1));

  assert_ready_drop_R4: assert property (@(posedge clk) disable iff (!mrst_n)
    (fwft && $fell(ef_or)) |-> $past(!rd_n || !rt_n || !prst_n));

  assert_half_not_empty_R6: assert property (@(posedge clk) disable iff (!mrst_n)
    (!fwft && ef_or) |-> !half_full);
endmodule

bind fifo_rdctl fifo_rdctl_chk #(.AW(AW), .W(W)) u_chk (
  .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .rd_n(rd_n), .rt_n(rt_n),
  .fwft(fwft), .zlat(zlat), .ef_or(ef_or), .ff_ir(ff_ir),
  .half_full(half_full), .dout(dout), .wptr(wptr), .rptr(rptr)
);

// File: tb/sim_fifo_rdctl.sv
module sim_fifo_rdctl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic mrst_n, prst_n, fall_pin, rtlat_n, wr_n, rd_n, rt_n;
  logic [W-1:0] din;
  logic [W-1:0] dout;
  logic ef_or, ff_ir, half_full;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_rdctl #(.W(W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .fall_pin(fall_pin),
    .rtlat_n(rtlat_n), .wr_n(wr_n), .din(din), .rd_n(rd_n), .rt_n(rt_n),
    .dout(dout), .ef_or(ef_or), .ff_ir(ff_ir), .half_full(half_full)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_mrst(input logic fall, input logic rtl);
    mrst_n = 1'b0; fall_pin = fall; rtlat_n = rtl;
    tick(); tick();
    mrst_n = 1'b1;
  endtask

  task automatic wr(input logic [W-1:0] v);
    wr_n = 1'b0; din = v; tick(); wr_n = 1'b1;
  endtask

  task automatic rd();
    rd_n = 1'b0; tick(); rd_n = 1'b1;
  endtask

  task automatic t_reset_std();
    do_mrst(1'b0, 1'b1);
    chk("R1 empty", ef_or, 1); chk("R1 full", ff_ir, 0);
    chk("R1 half", half_full, 0); chk("R1 dout", dout, 0);
  endtask

  task automatic t_std_order();
    wr(8'hA1);
    chk("R2 no fall-through", dout, 0); chk("R2 not empty", ef_or, 0);
    rd();
    chk("R2 first read", dout, 8'hA1); chk("R2 empty again", ef_or, 1);
    wr(8'h11); wr(8'h22); wr(8'h33);
    rd(); chk("R2 order 1", dout, 8'h11);
    rd(); chk("R2 order 2", dout, 8'h22);
    rd(); chk("R2 order 3", dout, 8'h33);
  endtask

  task automatic t_empty_read();
    rd();
    chk("R3 dout held", dout, 8'h33); chk("R3 still empty", ef_or, 1);
    wr(8'h44); rd();
    chk("R3 no pointer slip", dout, 8'h44);
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++) begin
      wr(8'h40 + 8'(i));
      if (i == 7) chk("R6 half at 8", half_full, 0);
      if (i == 8) chk("R6 half at 9", half_full, 1);
      if (i == DEPTH-2) chk("R5 not yet full", ff_ir, 0);
    end
    chk("R5 full", ff_ir, 1);
    wr(8'hEE);
    for (int i = 0; i < DEPTH; i++) begin
      rd();
      chk("R5 readback", dout, 8'h40 + i);
      if (i == 7) chk("R6 half at 8 after reads", half_full, 0);
    end
    chk("R5 extra write dropped", ef_or, 1);
  endtask

  task automatic t_fwft();
    do_mrst(1'b1, 1'b1);
    chk("R1 fwft not ready", ef_or, 0); chk("R1 fwft input ready", ff_ir, 1);
    wr(8'h5A);
    chk("R4 not yet ready", ef_or, 0);
    tick();
    chk("R4 ready", ef_or, 1); chk("R4 first word", dout, 8'h5A);
    wr(8'h5B); wr(8'h5C); tick();
    chk("R4 held without read", dout, 8'h5A);
    rd(); chk("R4 next", dout, 8'h5B);
    rd(); chk("R4 next 2", dout, 8'h5C); chk("R4 still ready", ef_or, 1);
    rd(); chk("R4 ready drops", ef_or, 0);
  endtask

  task automatic t_rt_normal();
    rt_n = 1'b0; rd_n = 1'b0; tick();
    rt_n = 1'b1;
    chk("R8 gap not ready", ef_or, 0);
    tick();
    rd_n = 1'b1;
    chk("R8 first word late", dout, 8'h5A); chk("R8 ready", ef_or, 1);
    rd(); chk("R8 gap read ignored", dout, 8'h5B);
  endtask

  task automatic t_rt_zero();
    do_mrst(1'b0, 1'b0);
    wr(8'h71); wr(8'h72); wr(8'h73);
    rd(); rd(); chk("R7 pre", dout, 8'h72);
    rt_n = 1'b0; tick(); rt_n = 1'b1;
    chk("R7 same edge", dout, 8'h71);
    rd(); chk("R7 second", dout, 8'h72);
    rd(); chk("R7 third", dout, 8'h73); chk("R7 empty", ef_or, 1);
  endtask

  task automatic t_prst();
    do_mrst(1'b1, 1'b1);
    wr(8'h81); tick();
    chk("R9 pre ready", ef_or, 1);
    prst_n = 1'b0; tick(); prst_n = 1'b1;
    chk("R9 ready cleared", ef_or, 0); chk("R9 input ready", ff_ir, 1);
    chk("R9 dout cleared", dout, 0);
    wr(8'h91); tick();
    chk("R9 fwft kept", ef_or, 1); chk("R9 fwft data", dout, 8'h91);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    mrst_n = 1'b0; prst_n = 1'b1; fall_pin = 1'b0; rtlat_n = 1'b1;
    wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1; din = '0;
    #1;
    t_reset_std();
    t_std_order();
    t_empty_read();
    t_fill();
    t_fwft();
    t_rt_normal();
    t_rt_zero();
    t_prst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule